// File: doc/BRIEF.md
# Adjustable Nanosecond Time Counter

This block keeps a running nanosecond time value for precision time protocol work. On every reference clock cycle in which it runs, it adds a programmable step to its count. Software trims the clock rate by asking the block to use a second step once every N counting cycles. A 1 ns base step with a 2 or 0 ns second step then gives a fine rate trim that stays exact over time.

All settings arrive through a single write port that carries an address and a data word. A control word sets the counter running, picks the period behaviour and routes the period event to a pin output. The same word also carries two self-clearing commands. Restart clears the count. Snapshot copies the live count into the readable output. A write to the value address loads the counter directly. A programmable event period can act as the counter's modulus, or it can simply mark the moment the count passes it.

Top module: `ns_time_counter`

## Requirements
- R1: After synchronous reset the count, the snapshot output and both event outputs are zero, and every register reads as zero.
- R2: While the run bit (control address 0, bit 0) is clear, the count holds its value.
- R3: While running with correction off, each cycle adds the base step, which is taken from bits 6:0 of the step register at address 4.
- R4: When the correction interval N at address 3 is nonzero, every Nth counting cycle adds the trim step from bits 14:8 of address 4 in place of the base step.
- R5: A correction interval of zero turns correction off, so every counting cycle uses the base step.
- R6: A write to the correction interval register restarts the count of cycles toward the next correction from zero.
- R7: Writing control address 0 with bit 11 set copies the count as it stood before that cycle's update into `snap_q`, visible on the next cycle. The snapshot holds until the next such command.
- R8: A write to address 1 loads the written value into the count, replacing that cycle's step.
- R9: Writing control address 0 with bit 9 set clears the count to zero in that cycle.
- R10: With control bits 5 and 4 both set, a step that reaches or passes the event period at address 2 leaves the count at the step result minus the period, and raises `tick_evt` for one cycle.
- R11: With bit 4 set and bit 5 clear, `tick_evt` pulses once when a step takes the count from below the period to at or above it. The count keeps rising.
- R12: `pin_evt` repeats each `tick_evt` pulse only while control bit 7 is set, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 value, 2 period, 3 correction interval, 4 steps |
| wr_data | input | 32 | Register write data |
| snap_q | output | CW (32) | Count captured by the last snapshot command |
| tick_evt | output | 1 | One-cycle period event |
| pin_evt | output | 1 | Period event routed to the pin output |

## Verification
The assertions assume one write per cycle. They also assume that a restart and a value load never coincide with any other write to the same register. The stimulus satisfies this by going through a single write task that drives one address per clock and then drops the strobe. They further assume that the event period stays fixed while a wrap check is active. The stimulus writes the period, the steps and the interval before it sets the run bit, and it changes them only under reset or through the interval write that exercises R6.

// File: rtl/nstc_pkg.sv
package nstc_pkg;
  localparam int DW = 32;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    A_CTRL   = 3'd0,
    A_VALUE  = 3'd1,
    A_PERIOD = 3'd2,
    A_CORR   = 3'd3,
    A_STEPS  = 3'd4
  } reg_addr_e;

  localparam int B_RUN     = 0;
  localparam int B_EVT     = 4;
  localparam int B_WRAP    = 5;
  localparam int B_ROUTE   = 7;
  localparam int B_RESTART = 9;
  localparam int B_SNAP    = 11;
  localparam int STEP_BASE_LSB = 0;
  localparam int STEP_TRIM_LSB = 8;

  typedef struct packed {
    logic route;
    logic wrap;
    logic evt;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/nstc_regs.sv
module nstc_regs
  import nstc_pkg::*;
#(
  parameter int CW  = 32,
  parameter int IW  = 7,
  parameter int CPW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  output ctrl_t          ctrl_q,
  output logic           restart_p,
  output logic           snap_p,
  output logic           load_p,
  output logic [CW-1:0]  load_val,
  output logic [CW-1:0]  period_q,
  output logic [CPW-1:0] corr_per_q,
  output logic           corr_wr_p,
  output logic [IW-1:0]  step_base_q,
  output logic [IW-1:0]  step_trim_q
);
  logic sel_ctrl, sel_value, sel_period, sel_corr, sel_steps;

  always_comb begin
    sel_ctrl   = wr_en && (wr_addr == A_CTRL);
    sel_value  = wr_en && (wr_addr == A_VALUE);
    sel_period = wr_en && (wr_addr == A_PERIOD);
    sel_corr   = wr_en && (wr_addr == A_CORR);
    sel_steps  = wr_en && (wr_addr == A_STEPS);
  end

  assign restart_p = sel_ctrl && wr_data[B_RESTART];
  assign snap_p    = sel_ctrl && wr_data[B_SNAP];
  assign load_p    = sel_value;
  assign load_val  = wr_data[CW-1:0];
  assign corr_wr_p = sel_corr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      period_q    <= '0;
      corr_per_q  <= '0;
      step_base_q <= '0;
      step_trim_q <= '0;
    end else begin
      if (sel_ctrl) begin
        ctrl_q.run   <= wr_data[B_RUN];
        ctrl_q.evt   <= wr_data[B_EVT];
        ctrl_q.wrap  <= wr_data[B_WRAP];
        ctrl_q.route <= wr_data[B_ROUTE];
      end
      if (sel_period) period_q <= wr_data[CW-1:0];
      if (sel_corr)   corr_per_q <= wr_data[CPW-1:0];
      if (sel_steps) begin
        step_base_q <= wr_data[STEP_BASE_LSB +: IW];
        step_trim_q <= wr_data[STEP_TRIM_LSB +: IW];
      end
    end
  end
endmodule

// File: rtl/nstc_trim.sv
module nstc_trim #(
  parameter int IW  = 7,
  parameter int CPW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic [CPW-1:0] corr_per,
  input  logic           corr_wr,
  input  logic [IW-1:0]  step_base,
  input  logic [IW-1:0]  step_trim,
  output logic [IW-1:0]  step_sel,
  output logic           corr_fire
);
  localparam logic [CPW-1:0] ONE = CPW'(1);

  logic [CPW-1:0] gap_q;
  logic           corr_on;

  assign corr_on   = (corr_per != '0);
  assign corr_fire = step && corr_on && (gap_q == corr_per - ONE);
  assign step_sel  = corr_fire ? step_trim : step_base;

  always_ff @(posedge clk) begin
    if (rst || corr_wr) begin
      gap_q <= '0;
    end else if (step && corr_on) begin
      gap_q <= corr_fire ? '0 : gap_q + ONE;
    end
  end
endmodule

// File: rtl/nstc_accum.sv
module nstc_accum
  import nstc_pkg::*;
#(
  parameter int CW = 32,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrl_t         ctrl_q,
  input  logic          restart_p,
  input  logic          load_p,
  input  logic [CW-1:0] load_val,
  input  logic          snap_p,
  input  logic [CW-1:0] period,
  input  logic [IW-1:0] step_sel,
  output logic          step,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] snap_q,
  output logic          tick_evt,
  output logic          pin_evt
);
  localparam int XW = CW + 1;

  logic [XW-1:0] sum;
  logic [XW-1:0] per_x;
  logic [XW-1:0] folded;
  logic          hit;
  logic          fold;

  always_comb begin
    step   = ctrl_q.run && !restart_p && !load_p;
    sum    = {1'b0, cnt_q} + XW'(step_sel);
    per_x  = {1'b0, period};
    folded = sum - per_x;
    hit    = step && ({1'b0, cnt_q} < per_x) && (sum >= per_x);
    fold   = hit && ctrl_q.evt && ctrl_q.wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      snap_q   <= '0;
      tick_evt <= 1'b0;
      pin_evt  <= 1'b0;
    end else begin
      if (restart_p)   cnt_q <= '0;
      else if (load_p) cnt_q <= load_val;
      else if (step)   cnt_q <= fold ? folded[CW-1:0] : sum[CW-1:0];
      if (snap_p) snap_q <= cnt_q;
      tick_evt <= hit && ctrl_q.evt;
      pin_evt  <= hit && ctrl_q.evt && ctrl_q.route;
    end
  end
endmodule

// File: rtl/ns_time_counter.sv
module ns_time_counter
  import nstc_pkg::*;
#(
  parameter int CW  = 32,
  parameter int IW  = 7,
  parameter int CPW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [31:0]   wr_data,
  output logic [CW-1:0] snap_q,
  output logic          tick_evt,
  output logic          pin_evt
);
  ctrl_t          ctrl_q;
  logic           restart_p, snap_p, load_p, corr_wr_p;
  logic [CW-1:0]  load_val, period_q, cnt_q;
  logic [CPW-1:0] corr_per_q;
  logic [IW-1:0]  step_base_q, step_trim_q, step_sel;
  logic           step, corr_fire, run_q;

  assign run_q = ctrl_q.run;

  nstc_regs #(.CW(CW), .IW(IW), .CPW(CPW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .restart_p(restart_p), .snap_p(snap_p), .load_p(load_p),
    .load_val(load_val), .period_q(period_q), .corr_per_q(corr_per_q),
    .corr_wr_p(corr_wr_p), .step_base_q(step_base_q), .step_trim_q(step_trim_q)
  );

  nstc_trim #(.IW(IW), .CPW(CPW)) u_trim (
    .clk(clk), .rst(rst), .step(step), .corr_per(corr_per_q), .corr_wr(corr_wr_p),
    .step_base(step_base_q), .step_trim(step_trim_q), .step_sel(step_sel),
    .corr_fire(corr_fire)
  );

  nstc_accum #(.CW(CW), .IW(IW)) u_accum (
    .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .restart_p(restart_p), .load_p(load_p),
    .load_val(load_val), .snap_p(snap_p), .period(period_q), .step_sel(step_sel),
    .step(step), .cnt_q(cnt_q), .snap_q(snap_q), .tick_evt(tick_evt),
    .pin_evt(pin_evt)
  );
endmodule

// File: rtl/nstc_chk.sv
module nstc_chk #(
  parameter int CW  = 32,
  parameter int CPW = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic [2:0]     wr_addr,
  input logic [31:0]    wr_data,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  snap_q,
  input logic           run_q,
  input logic [CPW-1:0] corr_per,
  input logic           corr_fire,
  input logic           tick_evt,
  input logic           pin_evt
);
  logic wr_ctrl, wr_val;
  assign wr_ctrl = wr_en && (wr_addr == 3'd0);
  assign wr_val  = wr_en && (wr_addr == 3'd1);

  a_r7_snap_takes_count: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && wr_data[11]) |=> (snap_q == $past(cnt)));

  a_r8_load_value: assert property (@(posedge clk) disable iff (rst)
    wr_val |=> (cnt == $past(wr_data[CW-1:0])));

  a_r9_restart_zero: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && wr_data[9]) |=> (cnt == '0));

  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wr_val && !(wr_ctrl && wr_data[9])) |=> $stable(cnt));

  a_r5_no_trim_when_zero: assert property (@(posedge clk) disable iff (rst)
    (corr_per == '0) |-> !corr_fire);

  a_r12_pin_follows_tick: assert property (@(posedge clk) disable iff (rst)
    pin_evt |-> tick_evt);
endmodule

bind ns_time_counter nstc_chk #(.CW(CW), .CPW(CPW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cnt(cnt_q), .snap_q(snap_q), .run_q(run_q), .corr_per(corr_per_q),
  .corr_fire(corr_fire), .tick_evt(tick_evt), .pin_evt(pin_evt)
);

// File: tb/sim_ns_time_counter.sv
module sim_ns_time_counter;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SNAP = 32'h800;
  localparam logic [31:0] RSTRT = 32'h200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] snap_q;
  logic        tick_evt, pin_evt;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;
  int tick_cnt = 0;
  int pin_cnt = 0;
  logic saw_cap = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ns_time_counter u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .snap_q(snap_q), .tick_evt(tick_evt), .pin_evt(pin_evt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard one cycle after each snapshot command
  always @(posedge clk) begin
    saw_cap  <= wr_en && (wr_addr == 3'd0) && wr_data[11];
    tick_cnt <= tick_cnt + int'(tick_evt);
    pin_cnt  <= pin_cnt + int'(pin_evt);
  end

  always @(negedge clk) begin
    if (saw_cap) begin
      if (exp_q.size() == 0) begin
        check("scoreboard empty", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), snap_q, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cap(input logic [31:0] ctrl, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    wr(3'd0, ctrl | SNAP);
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0;
    idle(2);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int t0, p0;
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 snap after reset", snap_q, 0);
    check("R1 tick after reset", {31'd0, tick_evt}, 0);
    check("R1 pin after reset", {31'd0, pin_evt}, 0);
    idle(3);
    cap(32'h0, 32'd0, "R1 count after reset");
    idle(2);

    // R2 holds while run bit clear
    do_reset();
    wr(3'd4, 32'd5);
    wr(3'd1, 32'd100);
    idle(10);
    cap(32'h0, 32'd100, "R2 hold first");
    idle(5);
    cap(32'h0, 32'd100, "R2 hold second");
    idle(2);

    // R3 base step, R7 snapshot semantics
    do_reset();
    wr(3'd4, 32'd5);
    wr(3'd1, 32'd100);
    wr(3'd0, 32'h1);
    idle(10);
    cap(32'h1, 32'd150, "R3/R7 base step 5 over 10 cycles");
    idle(6);
    check("R7 snapshot holds", snap_q, 32'd150);

    // R4 correction every 4th step
    do_reset();
    wr(3'd4, 32'd2 | (32'd9 << 8));
    wr(3'd3, 32'd4);
    wr(3'd0, 32'h1);
    idle(10);
    cap(32'h1, 32'd34, "R4 trim every 4th step");
    idle(2);

    // R5 interval zero
    do_reset();
    wr(3'd4, 32'd2 | (32'd9 << 8));
    wr(3'd0, 32'h1);
    idle(10);
    cap(32'h1, 32'd20, "R5 no trim with interval 0");
    idle(2);

    // R6 interval write restarts the trim count
    do_reset();
    wr(3'd4, 32'd2 | (32'd9 << 8));
    wr(3'd3, 32'd4);
    wr(3'd0, 32'h1);
    idle(2);
    wr(3'd3, 32'd4);
    idle(5);
    cap(32'h1, 32'd23, "R6 trim count restarts on write");
    idle(2);

    // R8 load while running
    do_reset();
    wr(3'd4, 32'd1);
    wr(3'd0, 32'h1);
    idle(2);
    wr(3'd1, 32'd1000);
    idle(3);
    cap(32'h1, 32'd1003, "R8 load value");
    idle(2);

    // R9 restart
    do_reset();
    wr(3'd4, 32'd3);
    wr(3'd1, 32'd500);
    wr(3'd0, 32'h1);
    idle(2);
    wr(3'd0, 32'h1 | RSTRT);
    idle(4);
    cap(32'h1, 32'd12, "R9 restart clears");
    idle(2);

    // R10 modulus mode
    do_reset();
    wr(3'd4, 32'd3);
    wr(3'd2, 32'd10);
    wr(3'd0, 32'h31);
    t0 = tick_cnt; p0 = pin_cnt;
    idle(6);
    cap(32'h31, 32'd8, "R10 folded count");
    idle(2);
    check("R10 tick pulses", tick_cnt - t0, 2);
    check("R12 pin quiet without route", pin_cnt - p0, 0);

    // R11 pass-through event
    do_reset();
    wr(3'd4, 32'd3);
    wr(3'd2, 32'd10);
    wr(3'd0, 32'h11);
    t0 = tick_cnt;
    idle(6);
    cap(32'h11, 32'd18, "R11 count keeps rising");
    idle(2);
    check("R11 single tick", tick_cnt - t0, 1);

    // R12 routed event
    do_reset();
    wr(3'd4, 32'd3);
    wr(3'd2, 32'd10);
    wr(3'd0, 32'h91);
    t0 = tick_cnt; p0 = pin_cnt;
    idle(8);
    check("R12 pin follows tick", pin_cnt - p0, 1);
    check("R12 tick with route", tick_cnt - t0, 1);

    // R12 route without event enable
    do_reset();
    wr(3'd4, 32'd3);
    wr(3'd2, 32'd10);
    wr(3'd0, 32'h81);
    t0 = tick_cnt; p0 = pin_cnt;
    idle(8);
    check("R12 pin quiet without event bit", pin_cnt - p0, 0);

    check("scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule